// File: doc/BRIEF.md
# Two-Instruction-Word Accumulator Processor

A multicycle accumulator processor built around a 40-bit word memory. Each word carries two 20-bit instructions. The core fetches a word, runs the left instruction, and then runs the right instruction from an instruction buffer without a second memory access.

The machine has one accumulator and a multiplier/quotient register. It can move data, add and subtract with absolute-value variants, multiply and divide, shift, and jump to either half of a word. It can also rewrite only the 12-bit address field of a stored instruction, which allows self-modifying programs.

A host fills memory through the program-load port while the core is halted. It then pulses `start_i`, waits for `halted_o`, and reads results back through the same port. Execution always begins at the left instruction of word 0.

Top module: `acc2w_cpu`

## Requirements
- R1: After reset `halted_o` is 1, `acc_o` is 0 and `div_err_o` is 0.
- R2: In a stored word (bit 39 = MSB), the left instruction is opcode [39:32] with address [31:20], and the right instruction is opcode [19:12] with address [11:0]. One fetch runs the left instruction and then the right one. After the right instruction the next sequential word is fetched.
- R3: Loads into AC are 0x01 (M(X)), 0x02 (−M(X)), 0x03 (|M(X)|), 0x04 (−|M(X)|) and 0x0A (MQ). Opcode 0x09 loads M(X) into MQ.
- R4: 0x05 adds M(X) to AC, 0x07 adds |M(X)|, 0x06 subtracts M(X) and 0x08 subtracts |M(X)|. All of these use 40-bit two's complement arithmetic that wraps on overflow.
- R5: 0x21 stores AC into M(X). Stored words can be read back on `load_rdata_o` while the core is halted.
- R6: 0x0D jumps to the left instruction of word X, and 0x0E jumps to the right instruction of word X. After a right-half jump only that right instruction runs before the next word is fetched. A taken jump discards the buffered right instruction.
- R7: 0x0F and 0x10 jump like 0x0D and 0x0E, but only when AC[39] is 0. Otherwise execution falls through.
- R8: 0x0B forms the signed 80-bit product of M(X) and MQ. The upper 40 bits go to AC and the lower 40 bits go to MQ.
- R9: 0x0C divides AC by M(X) as signed values. The quotient, truncated toward zero, goes to MQ. The remainder, which takes the dividend's sign, goes to AC.
- R10: Dividing by zero sets `div_err_o` and halts with AC unchanged. The flag stays set until reset.
- R11: 0x14 shifts AC left one bit, inserting 0. 0x15 shifts AC right one bit and keeps the sign bit.
- R12: 0x12 replaces bits [31:20] of M(X) with AC[11:0], and 0x13 replaces bits [11:0]. Every other bit of the word is kept.
- R13: Any other opcode, including 0x00, halts the core without changing AC. While halted, AC holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted while halted, begins at word 0 left |
| load_we_i | input | 1 | Program-load write enable, honoured while halted |
| load_addr_i | input | 12 | Program-load address for writes and readback |
| load_data_i | input | 40 | Program-load write data |
| load_rdata_o | output | 40 | Memory word at `load_addr_i` |
| halted_o | output | 1 | Core is halted |
| acc_o | output | 40 | Accumulator |
| div_err_o | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench targets the following corner cases:
- **Wraparound add from the largest positive value.** A core that saturates or sign-extends would miss the wrap to the most negative value.
- **Conditional jump with AC exactly zero.** A core that tests "positive" instead of "nonnegative" would fall through.
- **Right-half jump.** The landing word carries a poisoned left instruction, so a core that also runs the left half leaves a wrong sum.
- **Mixed-sign division and a power-of-two multiply.** These expose sign fix-up and bit-order errors in the iterative unit. A floor-rounding divider, for example, returns −4/3 instead of −3/−2.
- **Self-modifying store.** The store's own address field is rewritten before it runs; a core that ignores the update overwrites word 0.
- **Divide by zero and an undefined opcode.** Both must stop the core with AC intact and no further stores.

// File: rtl/acc2w_pkg.sv
package acc2w_pkg;
  localparam int WORD_W = 40;
  localparam int INS_W  = 20;
  localparam int OP_W   = 8;
  localparam int ADR_W  = 12;

  typedef enum logic [OP_W-1:0] {
    OP_LD      = 8'h01,
    OP_LD_NEG  = 8'h02,
    OP_LD_ABS  = 8'h03,
    OP_LD_NABS = 8'h04,
    OP_ADD     = 8'h05,
    OP_SUB     = 8'h06,
    OP_ADD_ABS = 8'h07,
    OP_SUB_ABS = 8'h08,
    OP_LD_MQ_M = 8'h09,
    OP_LD_MQ   = 8'h0A,
    OP_MUL     = 8'h0B,
    OP_DIV     = 8'h0C,
    OP_JMP_L   = 8'h0D,
    OP_JMP_R   = 8'h0E,
    OP_JGE_L   = 8'h0F,
    OP_JGE_R   = 8'h10,
    OP_AMOD_L  = 8'h12,
    OP_AMOD_R  = 8'h13,
    OP_SHL     = 8'h14,
    OP_SHR     = 8'h15,
    OP_ST      = 8'h21
  } opcode_e;

  typedef enum logic [1:0] {ST_HALT, ST_FETCH, ST_EXEC, ST_WAIT} state_e;
endpackage

// File: rtl/acc2w_mem.sv
module acc2w_mem #(
  parameter int DEPTH = 4096,
  parameter int W     = 40,
  parameter int AW    = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i[IDX_W-1:0]] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i[IDX_W-1:0]];
  assign rdata_b_o = mem_q[raddr_b_i[IDX_W-1:0]];
endmodule

// File: rtl/acc2w_alu.sv
module acc2w_alu
  import acc2w_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    ac_i,
  input  logic [W-1:0]    mq_i,
  input  logic [W-1:0]    opnd_i,
  output logic [W-1:0]    ac_o,
  output logic            hit_o
);
  logic [W-1:0] mag;

  assign mag = opnd_i[W-1] ? -opnd_i : opnd_i;

  always_comb begin
    hit_o = 1'b1;
    ac_o  = ac_i;
    case (op_i)
      OP_LD:      ac_o = opnd_i;
      OP_LD_NEG:  ac_o = -opnd_i;
      OP_LD_ABS:  ac_o = mag;
      OP_LD_NABS: ac_o = -mag;
      OP_LD_MQ:   ac_o = mq_i;
      OP_ADD:     ac_o = ac_i + opnd_i;
      OP_ADD_ABS: ac_o = ac_i + mag;
      OP_SUB:     ac_o = ac_i - opnd_i;
      OP_SUB_ABS: ac_o = ac_i - mag;
      OP_SHL:     ac_o = {ac_i[W-2:0], 1'b0};
      OP_SHR:     ac_o = {ac_i[W-1], ac_i[W-1:1]};
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc2w_muldiv.sv
module acc2w_muldiv #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         div_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic             busy_q, done_q, div_q, neg_a_q, neg_b_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     hi_q, lo_q, m_q;
  logic [W:0]       sum, trial;
  logic             ge;
  logic [2*W-1:0]   prod;

  // multiply step: conditional add then shift right; divide step: restoring
  assign sum   = {1'b0, hi_q} + (lo_q[0] ? {1'b0, m_q} : '0);
  assign trial = {hi_q, lo_q[W-1]};
  assign ge    = trial >= {1'b0, m_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      div_q   <= 1'b0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      m_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        div_q   <= div_i;
        neg_a_q <= a_i[W-1];
        neg_b_q <= b_i[W-1];
        cnt_q   <= '0;
        hi_q    <= '0;
        if (div_i) begin
          lo_q <= a_i[W-1] ? -a_i : a_i;
          m_q  <= b_i[W-1] ? -b_i : b_i;
        end else begin
          lo_q <= b_i[W-1] ? -b_i : b_i;
          m_q  <= a_i[W-1] ? -a_i : a_i;
        end
      end else if (busy_q) begin
        if (div_q) begin
          hi_q <= W'(ge ? trial - {1'b0, m_q} : trial);
          lo_q <= {lo_q[W-2:0], ge};
        end else begin
          hi_q <= sum[W:1];
          lo_q <= {sum[0], lo_q[W-1:1]};
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign prod   = (neg_a_q ^ neg_b_q) ? -{hi_q, lo_q} : {hi_q, lo_q};
  assign hi_o   = div_q ? (neg_a_q ? -hi_q : hi_q) : prod[2*W-1:W];
  assign lo_o   = div_q ? ((neg_a_q ^ neg_b_q) ? -lo_q : lo_q) : prod[W-1:0];
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_MD_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_MD_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i); // R9
endmodule

// File: rtl/acc2w_cpu.sv
module acc2w_cpu
  import acc2w_pkg::*;
#(
  parameter int DEPTH = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_we_i,
  input  logic [ADR_W-1:0]  load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  output logic [WORD_W-1:0] load_rdata_o,
  output logic              halted_o,
  output logic [WORD_W-1:0] acc_o,
  output logic              div_err_o
);
  localparam int W = WORD_W;

  state_e           state_q;
  logic [ADR_W-1:0] pc_q, mar_q;
  logic [OP_W-1:0]  ir_q;
  logic [INS_W-1:0] ibr_q;
  logic             ibr_v_q, go_right_q, div_err_q;
  logic [W-1:0]     ac_q, mq_q;

  logic [ADR_W-1:0] mem_raddr, mem_waddr;
  logic [W-1:0]     mem_rdata, mem_wdata, cpu_wdata;
  logic             mem_we, cpu_we;
  logic [W-1:0]     alu_ac;
  logic             alu_hit;
  logic             is_div, is_jge, jmp_take, md_start, exec_adv, adv;
  logic             md_busy, md_done;
  logic [W-1:0]     md_hi, md_lo;

  assign mem_raddr = (state_q == ST_FETCH) ? pc_q : mar_q;
  assign is_div    = ir_q == OP_DIV;
  assign is_jge    = (ir_q == OP_JGE_L) || (ir_q == OP_JGE_R);

  always_comb begin
    cpu_we    = 1'b0;
    cpu_wdata = mem_rdata;
    case (ir_q)
      OP_ST:     begin cpu_we = 1'b1; cpu_wdata = ac_q; end
      OP_AMOD_L: begin cpu_we = 1'b1; cpu_wdata[31:20] = ac_q[11:0]; end
      OP_AMOD_R: begin cpu_we = 1'b1; cpu_wdata[11:0]  = ac_q[11:0]; end
      default: ;
    endcase
    cpu_we = cpu_we && (state_q == ST_EXEC);
  end

  assign jmp_take = (state_q == ST_EXEC) &&
                    ((ir_q == OP_JMP_L) || (ir_q == OP_JMP_R) || (is_jge && !ac_q[W-1]));
  assign md_start = (state_q == ST_EXEC) &&
                    ((ir_q == OP_MUL) || (is_div && (mem_rdata != '0)));
  assign exec_adv = (state_q == ST_EXEC) &&
                    (alu_hit || cpu_we || (ir_q == OP_LD_MQ_M) || (is_jge && ac_q[W-1]));
  assign adv      = exec_adv || ((state_q == ST_WAIT) && md_done);

  assign mem_we    = cpu_we || (load_we_i && (state_q == ST_HALT));
  assign mem_waddr = cpu_we ? mar_q : load_addr_i;
  assign mem_wdata = cpu_we ? cpu_wdata : load_data_i;

  acc2w_mem #(.DEPTH(DEPTH), .W(W), .AW(ADR_W)) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (mem_raddr),
    .rdata_a_o (mem_rdata),
    .raddr_b_i (load_addr_i),
    .rdata_b_o (load_rdata_o)
  );

  acc2w_alu #(.W(W)) u_alu (
    .op_i   (ir_q),
    .ac_i   (ac_q),
    .mq_i   (mq_q),
    .opnd_i (mem_rdata),
    .ac_o   (alu_ac),
    .hit_o  (alu_hit)
  );

  acc2w_muldiv #(.W(W)) u_md (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (md_start),
    .div_i   (is_div),
    .a_i     (is_div ? ac_q : mem_rdata),
    .b_i     (is_div ? mem_rdata : mq_q),
    .busy_o  (md_busy),
    .done_o  (md_done),
    .hi_o    (md_hi),
    .lo_o    (md_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HALT;
      pc_q       <= '0;
      mar_q      <= '0;
      ir_q       <= '0;
      ibr_q      <= '0;
      ibr_v_q    <= 1'b0;
      go_right_q <= 1'b0;
      div_err_q  <= 1'b0;
      ac_q       <= '0;
      mq_q       <= '0;
    end else begin
      case (state_q)
        ST_HALT: if (start_i) begin
          pc_q       <= '0;
          go_right_q <= 1'b0;
          ibr_v_q    <= 1'b0;
          state_q    <= ST_FETCH;
        end
        ST_FETCH: begin
          pc_q       <= pc_q + 1'b1;
          go_right_q <= 1'b0;
          state_q    <= ST_EXEC;
          if (go_right_q) begin
            ir_q    <= mem_rdata[19:12];
            mar_q   <= mem_rdata[11:0];
            ibr_v_q <= 1'b0;
          end else begin
            ir_q    <= mem_rdata[39:32];
            mar_q   <= mem_rdata[31:20];
            ibr_q   <= mem_rdata[19:0];
            ibr_v_q <= 1'b1;
          end
        end
        ST_EXEC: begin
          if (alu_hit) ac_q <= alu_ac;
          if (ir_q == OP_LD_MQ_M) mq_q <= mem_rdata;
          if (jmp_take) begin
            pc_q       <= mar_q;
            go_right_q <= (ir_q == OP_JMP_R) || (ir_q == OP_JGE_R);
            ibr_v_q    <= 1'b0;
            state_q    <= ST_FETCH;
          end else if (md_start) begin
            state_q <= ST_WAIT;
          end else if (!exec_adv) begin
            state_q <= ST_HALT;
            if (is_div) div_err_q <= 1'b1;
          end
        end
        ST_WAIT: if (md_done) begin
          ac_q <= md_hi;
          mq_q <= md_lo;
        end
        default: state_q <= ST_HALT;
      endcase
      if (adv) begin
        if (ibr_v_q) begin
          ir_q    <= ibr_q[19:12];
          mar_q   <= ibr_q[11:0];
          ibr_v_q <= 1'b0;
          state_q <= ST_EXEC;
        end else begin
          state_q <= ST_FETCH;
        end
      end
    end
  end

  assign halted_o  = state_q == ST_HALT;
  assign acc_o     = ac_q;
  assign div_err_o = div_err_q;

  AST_RIGHT_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && ibr_v_q) |=> (state_q == ST_EXEC) && !ibr_v_q); // R2
  AST_JUMP_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_take |=> (state_q == ST_FETCH) && !ibr_v_q && (pc_q == $past(mar_q))); // R6
  AST_SHL_DOUBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_EXEC) && (ir_q == OP_SHL)) |=> acc_o == {$past(acc_o[W-2:0]), 1'b0}); // R11
  AST_DIV_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |=> div_err_o); // R10
  AST_DIV_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_err_o) |-> (halted_o && $stable(acc_o))); // R10
  AST_HALT_HOLDS_AC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> (halted_o && $stable(acc_o))); // R13
  AST_WAIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !md_done) |-> md_busy); // R8
endmodule

// File: tb/acc2w_cpu_test.sv
module acc2w_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        load_we_i = 1'b0;
  logic [11:0] load_addr_i = '0;
  logic [39:0] load_data_i = '0;
  logic [39:0] load_rdata_o, acc_o;
  logic        halted_o, div_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc2w_cpu uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .load_we_i(load_we_i), .load_addr_i(load_addr_i), .load_data_i(load_data_i),
    .load_rdata_o(load_rdata_o), .halted_o(halted_o), .acc_o(acc_o),
    .div_err_o(div_err_o)
  );

  // {opcode, AC value at 100, operand at 101, MQ value at 103}
  localparam logic [127:0] VEC [NV] = '{
    {8'h01, 40'd0,   40'd123, 40'd7},
    {8'h02, 40'd0,   40'd5,   40'd7},
    {8'h03, 40'd0,   -40'sd9, 40'd7},
    {8'h04, 40'd0,   40'd9,   40'd7},
    {8'h0A, 40'd1,   40'd2,   40'd77},
    {8'h09, 40'd11,  40'd31,  40'd7},
    {8'h05, 40'd100, -40'sd30, 40'd0},
    {8'h05, 40'h7F_FFFF_FFFF, 40'd1, 40'd0},
    {8'h07, 40'd10,  -40'sd4, 40'd0},
    {8'h06, 40'd10,  40'd25,  40'd0},
    {8'h08, 40'd10,  -40'sd3, 40'd0},
    {8'h0B, 40'd0,   -40'sd7, 40'd6},
    {8'h0B, 40'd0,   40'h40_0000_0000, 40'd12},
    {8'h0C, -40'sd17, 40'd5,  40'd0},
    {8'h0C, 40'd100, -40'sd7, 40'd0},
    {8'h14, -40'sd3, 40'd0,   40'd0},
    {8'h15, -40'sd7, 40'd0,   40'd0},
    {8'h15, 40'd6,   40'd0,   40'd0}
  };

  function automatic logic [19:0] ins(input logic [7:0] op, input int adr);
    return {op, 12'(adr)};
  endfunction

  function automatic logic [79:0] model(input logic [7:0] op, input logic signed [39:0] a,
                                        input logic signed [39:0] b, input logic signed [39:0] q);
    logic signed [39:0] ab, ac, mq;
    logic signed [79:0] p;
    ab = b[39] ? -b : b;
    ac = a;
    mq = q;
    case (op)
      8'h01: ac = b;
      8'h02: ac = -b;
      8'h03: ac = ab;
      8'h04: ac = -ab;
      8'h0A: ac = q;
      8'h09: mq = b;
      8'h05: ac = a + b;
      8'h07: ac = a + ab;
      8'h06: ac = a - b;
      8'h08: ac = a - ab;
      8'h0B: begin p = b * q; ac = p[79:40]; mq = p[39:0]; end
      8'h0C: begin ac = a % b; mq = a / b; end
      8'h14: ac = a <<< 1;
      8'h15: ac = a >>> 1;
      default: ;
    endcase
    return {ac, mq};
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [39:0] d);
    @(negedge clk);
    load_we_i = 1'b1;
    load_addr_i = 12'(a);
    load_data_i = d;
    @(negedge clk);
    load_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [39:0] d);
    load_addr_i = 12'(a);
    #1;
    d = load_rdata_o;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 8; i++) wr(i, 40'd0);
  endtask

  task automatic run_prog(input string req);
    int n;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!halted_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted_o) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s actual=running expected=halted", req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [39:0] d;
    logic [79:0] e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halted", 40'(halted_o), 40'd1);
    chk("R1 acc", acc_o, 40'd0);
    chk("R1 err", 40'(div_err_o), 40'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R8 R9 R11 table walk
    for (int v = 0; v < NV; v++) begin
      clear_prog();
      wr(0, {ins(8'h09, 103), ins(8'h01, 100)});
      wr(1, {ins(VEC[v][127:120], 101), ins(8'h21, 102)});
      wr(2, {ins(8'h0A, 0), ins(8'h21, 104)});
      wr(100, VEC[v][119:80]);
      wr(101, VEC[v][79:40]);
      wr(103, VEC[v][39:0]);
      run_prog("R2 vector run");
      e = model(VEC[v][127:120], VEC[v][119:80], VEC[v][79:40], VEC[v][39:0]);
      rd(102, d);
      chk($sformatf("R3/R4/R8/R9/R11 AC vec %0d", v), d, e[79:40]);
      rd(104, d);
      chk($sformatf("R2/R5 MQ vec %0d", v), d, e[39:0]);
    end

    // R6 unconditional jumps, right-half lands on right instruction only
    clear_prog();
    wr(0, {ins(8'h01, 100), ins(8'h0D, 4)});
    wr(1, {ins(8'h05, 100), ins(8'h21, 105)});
    wr(4, {ins(8'h05, 100), ins(8'h0E, 6)});
    wr(6, {ins(8'h05, 100), ins(8'h21, 102)});
    wr(100, 40'd5);
    wr(102, 40'd0);
    wr(105, 40'd0);
    run_prog("R6 jumps");
    rd(102, d); chk("R6 right-half sum", d, 40'd10);
    rd(105, d); chk("R6 skipped store", d, 40'd0);

    // R7 conditional not taken on negative AC
    clear_prog();
    wr(0, {ins(8'h01, 106), ins(8'h0F, 4)});
    wr(1, {ins(8'h21, 102), ins(8'h00, 0)});
    wr(4, {ins(8'h21, 105), ins(8'h00, 0)});
    wr(106, -40'sd3);
    wr(102, 40'h55);
    wr(105, 40'h55);
    run_prog("R7 negative");
    rd(102, d); chk("R7 fallthrough store", d, -40'sd3);
    rd(105, d); chk("R7 no jump store", d, 40'h55);

    // R7 conditional taken at AC == 0 to right half
    clear_prog();
    wr(0, {ins(8'h01, 107), ins(8'h10, 4)});
    wr(1, {ins(8'h21, 105), ins(8'h00, 0)});
    wr(4, {ins(8'h21, 102), ins(8'h21, 105)});
    wr(107, 40'd0);
    wr(102, 40'h55);
    wr(105, 40'h55);
    run_prog("R7 zero");
    rd(105, d); chk("R7 taken right store", d, 40'd0);
    rd(102, d); chk("R7 left skipped", d, 40'h55);

    // R12 address-field modification, including self-modifying store
    clear_prog();
    wr(0, {ins(8'h01, 100), ins(8'h13, 1)});
    wr(1, {ins(8'h01, 101), ins(8'h21, 0)});
    wr(2, {ins(8'h01, 108), ins(8'h12, 110)});
    wr(3, {ins(8'h13, 110), ins(8'h00, 0)});
    wr(100, 40'd103);
    wr(101, 40'd42);
    wr(103, 40'd0);
    wr(108, 40'h00_0000_0ABC);
    wr(110, 40'hFF_FFFF_FFFF);
    run_prog("R12");
    rd(103, d); chk("R12 modified store target", d, 40'd42);
    rd(0, d);   chk("R12 word0 untouched", d, {ins(8'h01, 100), ins(8'h13, 1)});
    rd(110, d); chk("R12 both fields", d, 40'hFF_ABCF_FABC);

    // R13 undefined opcode halts, right half not run
    clear_prog();
    wr(0, {ins(8'h01, 100), ins(8'hFF, 0)});
    wr(1, {ins(8'h21, 102), ins(8'h00, 0)});
    wr(100, 40'd9);
    wr(102, 40'h77);
    run_prog("R13");
    chk("R13 acc kept", acc_o, 40'd9);
    rd(102, d); chk("R13 no store", d, 40'h77);
    repeat (5) @(negedge clk);
    chk("R13 acc stable halted", acc_o, 40'd9);

    // R10 divide by zero
    clear_prog();
    wr(0, {ins(8'h01, 100), ins(8'h0C, 101)});
    wr(1, {ins(8'h21, 102), ins(8'h00, 0)});
    wr(100, 40'd7);
    wr(101, 40'd0);
    wr(102, 40'h66);
    run_prog("R10");
    chk("R10 err set", 40'(div_err_o), 40'd1);
    chk("R10 acc kept", acc_o, 40'd7);
    rd(102, d); chk("R10 halted before store", d, 40'h66);
    clear_prog();
    wr(0, {ins(8'h01, 100), ins(8'h00, 0)});
    run_prog("R10 rerun");
    chk("R10 err sticky", 40'(div_err_o), 40'd1);

    // R1 reset again
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 err cleared", 40'(div_err_o), 40'd0);
    chk("R1 acc cleared", acc_o, 40'd0);
    rst_ni = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule